// File: doc/BRIEF.md
# Posted-Write Pending Tracker

This block is the register-write front end of a peripheral whose working registers sit in a slower functional clock domain. A simple bus in the bus clock domain presents an address, write data and a write or read request. A write that hits one of ten synchronized registers goes into a per-register holding slot, and a toggle handshake carries it into the functional domain. There the register takes the value and raises a one-cycle update strobe. While the write is in flight, the register's pending bit reads 1 in a pending-status register, so software can poll it before it reuses that register.

In posted mode a write finishes on the bus at once. A second write to the same register while its pending bit is set is dropped. In non-posted mode the bus is held off until the functional domain has acknowledged the write. A soft reset returns every functional register to zero, clears the tracking state and reports completion through a reset-done flag.

The bus request is a valid/ready pair. `bus_we` or `bus_re` is the valid, and the master holds the address, data and request until `bus_ready` is high at a rising edge of `clk_b`, which completes the transfer. Reads never stall, and read data is valid in the cycle the read is presented. Only a non-posted write to a synchronized register applies back-pressure.

Top module: `pw_tracker`

## Requirements
- R1: Each synchronized register owns a pending bit at a fixed position in the pending-status register at offset 0x34. Bit 0 is the register at 0x24, bit 1 is 0x28, bit 2 is 0x2C, bit 3 is 0x30, bit 4 is 0x38, and bits 5 to 9 are 0x48, 0x4C, 0x50, 0x54 and 0x58. All other bits read 0.
- R2: A posted write to a synchronized register completes with `bus_ready` high in the cycle it is presented. Its pending bit reads 1 from the next cycle until the functional domain has acknowledged the write.
- R3: Each accepted write updates the matching slice of `fn_regs` (lane i at bits i*DATA_W upward) exactly once with the written data. In the same functional-clock cycle the matching bit of `fn_wr_strobe` is high for one cycle. `fn_regs` changes only on such a strobe or a soft reset.
- R4: A posted write to a synchronized register whose pending bit is set is dropped. It has no effect on `fn_regs` or on the value read back.
- R5: A read of a synchronized register returns the last value the functional domain acknowledged. While a newer write is pending, the read returns the stale value.
- R6: Bit 2 of the interface-control register at offset 0x40 selects posted mode (1) or non-posted mode (0). It reads back at that position, and its reset value is 1.
- R7: In non-posted mode, a write to a synchronized register keeps `bus_ready` low until the write has been acknowledged, and its pending bit reads 0 once the write completes. Reads complete in the cycle they are presented.
- R8: Writing a 1 to bit 1 of the interface-control register starts a soft reset. Bit 0 of the system-status register at offset 0x14 reads 0 for at least RST_CYC functional-clock cycles and then 1. Afterwards all of `fn_regs` and every synchronized-register read return 0, the pending-status register reads 0, and posted mode is restored to 1. After a hardware reset, bit 0 of the system-status register reads 1.
- R9: Posted writes to synchronized registers while a soft reset is in progress are dropped.
- R10: Writes to any other offset set no pending bit and cause no functional update. Such offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_b | input | 1 | Bus clock |
| rst_b_n | input | 1 | Bus-domain reset, active low |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write request (valid) |
| bus_re | input | 1 | Read request (valid) |
| bus_ready | output | 1 | Transfer completes when high with a request |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of a read |
| clk_f | input | 1 | Functional clock |
| rst_f_n | input | 1 | Functional-domain reset, active low |
| fn_regs | output | 10*DATA_W | Functional-domain register values, lane i at bits i*DATA_W upward |
| fn_wr_strobe | output | 10 | One-cycle update pulse per lane, functional domain |

## Verification
The bench builds the block with DATA_W=32 and RST_CYC=8. The bus clock has a 10 ns period and the functional clock a 26 ns period. This ratio stretches every handshake round trip to about a dozen bus cycles, so a read of the pending-status register or a repeated write issued one cycle after a write always lands inside the pending window. With RST_CYC=8, the soft-reset busy window is long enough for a posted write issued just after the reset request to fall inside it, and for its minimum length to be measured from the bus side.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  localparam int NUM_LANES = 10;
  localparam int LANE_IW   = $clog2(NUM_LANES);
  localparam int ADDR_W    = 8;

  localparam logic [ADDR_W-1:0] OFS_SYSSTAT = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_PENDING = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_IFCTL   = 8'h40;
  localparam int IFCTL_SRST_BIT = 1;
  localparam int IFCTL_POST_BIT = 2;

  typedef struct packed {
    logic               hit;
    logic [LANE_IW-1:0] idx;
  } lane_sel_t;

  // lane position equals its pending-bit position
  function automatic lane_sel_t decode_lane(logic [ADDR_W-1:0] a);
    lane_sel_t s;
    s.hit = 1'b1;
    case (a)
      8'h24:   s.idx = LANE_IW'(0);
      8'h28:   s.idx = LANE_IW'(1);
      8'h2C:   s.idx = LANE_IW'(2);
      8'h30:   s.idx = LANE_IW'(3);
      8'h38:   s.idx = LANE_IW'(4);
      8'h48:   s.idx = LANE_IW'(5);
      8'h4C:   s.idx = LANE_IW'(6);
      8'h50:   s.idx = LANE_IW'(7);
      8'h54:   s.idx = LANE_IW'(8);
      8'h58:   s.idx = LANE_IW'(9);
      default: begin s.hit = 1'b0; s.idx = '0; end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/pwt_sync2.sv
module pwt_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pwt_lane.sv
module pwt_lane #(
  parameter int          DATA_W    = 32,
  parameter logic [31:0] RESET_VAL = '0
) (
  input  logic              clk_b,
  input  logic              rst_b_n,
  input  logic              launch,
  input  logic [DATA_W-1:0] wdata,
  input  logic              freeze,
  input  logic              shadow_clr,
  output logic              pend_raw,
  output logic [DATA_W-1:0] shadow,
  input  logic              clk_f,
  input  logic              rst_f_n,
  input  logic              f_clr,
  output logic [DATA_W-1:0] f_val,
  output logic              f_strobe
);
  localparam logic [DATA_W-1:0] RV = DATA_W'(RESET_VAL);

  logic              req_tgl, ack_s, ack_q;
  logic [DATA_W-1:0] hold;
  logic              req_s, seen;

  // bus side: holding slot and request toggle
  always_ff @(posedge clk_b or negedge rst_b_n) begin
    if (!rst_b_n) begin
      req_tgl <= 1'b0;
      hold    <= '0;
      shadow  <= RV;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= ack_s;
      if (launch) begin
        req_tgl <= ~req_tgl;
        hold    <= wdata;
      end
      if (shadow_clr)
        shadow <= RV;
      else if ((ack_s != ack_q) && !freeze)
        shadow <= hold;
    end
  end

  assign pend_raw = req_tgl ^ ack_s;

  pwt_sync2 #(.W(1)) u_req_sync (.clk(clk_f), .rst_n(rst_f_n), .d(req_tgl), .q(req_s));
  pwt_sync2 #(.W(1)) u_ack_sync (.clk(clk_b), .rst_n(rst_b_n), .d(seen),    .q(ack_s));

  // functional side: hold is stable while the toggle is in flight
  always_ff @(posedge clk_f or negedge rst_f_n) begin
    if (!rst_f_n) begin
      seen     <= 1'b0;
      f_val    <= RV;
      f_strobe <= 1'b0;
    end else begin
      f_strobe <= 1'b0;
      if (f_clr) begin
        f_val <= RV;
        seen  <= req_s;
      end else if (req_s != seen) begin
        f_val    <= hold;
        seen     <= req_s;
        f_strobe <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwt_srst.sv
module pwt_srst #(
  parameter int RST_CYC = 8
) (
  input  logic clk_b,
  input  logic rst_b_n,
  input  logic start,
  output logic busy,
  input  logic clk_f,
  input  logic rst_f_n,
  output logic f_clr
);
  localparam int CW = $clog2(RST_CYC + 1);

  logic          req_tgl, done_s, req_s, seen;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_b or negedge rst_b_n) begin
    if (!rst_b_n)   req_tgl <= 1'b0;
    else if (start) req_tgl <= ~req_tgl;
  end

  assign busy = req_tgl ^ done_s;

  pwt_sync2 #(.W(1)) u_req_sync  (.clk(clk_f), .rst_n(rst_f_n), .d(req_tgl), .q(req_s));
  pwt_sync2 #(.W(1)) u_done_sync (.clk(clk_b), .rst_n(rst_b_n), .d(seen),    .q(done_s));

  always_ff @(posedge clk_f or negedge rst_f_n) begin
    if (!rst_f_n) begin
      f_clr <= 1'b0;
      cnt   <= '0;
      seen  <= 1'b0;
    end else if (f_clr) begin
      if (cnt == CW'(RST_CYC - 1)) begin
        f_clr <= 1'b0;
        seen  <= req_s;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (req_s != seen) begin
      f_clr <= 1'b1;
      cnt   <= '0;
    end
  end
endmodule

// File: rtl/pw_tracker.sv
module pw_tracker
  import pwt_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int RST_CYC = 8
) (
  input  logic                        clk_b,
  input  logic                        rst_b_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  input  logic                        bus_we,
  input  logic                        bus_re,
  output logic                        bus_ready,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic                        clk_f,
  input  logic                        rst_f_n,
  output logic [NUM_LANES*DATA_W-1:0] fn_regs,
  output logic [NUM_LANES-1:0]        fn_wr_strobe
);
  lane_sel_t              sel;
  logic [NUM_LANES-1:0]   sel_vec, pend_raw, pend_vec, wr_launch;
  logic [DATA_W-1:0]      shadow [NUM_LANES];
  logic                   posted_q, np_busy, np_fin;
  logic                   resetting, f_clr, srst_start, ifctl_wr;
  logic                   sel_pend, np_req, launch_ok;

  assign sel      = decode_lane(bus_addr);
  assign sel_vec  = sel.hit ? (NUM_LANES'(1) << sel.idx) : '0;
  assign pend_vec = resetting ? '0 : pend_raw;
  assign sel_pend = |(pend_raw & sel_vec);

  // write launch and non-posted back-pressure
  assign np_req    = bus_we && sel.hit && !posted_q;
  assign launch_ok = bus_we && sel.hit && !resetting && !sel_pend &&
                     (posted_q || (!np_busy && !np_fin));
  assign wr_launch = launch_ok ? sel_vec : '0;
  assign bus_ready = np_req ? np_fin : 1'b1;

  always_ff @(posedge clk_b or negedge rst_b_n) begin
    if (!rst_b_n) begin
      np_busy <= 1'b0;
      np_fin  <= 1'b0;
    end else if (np_fin) begin
      np_fin <= 1'b0;
    end else if (np_busy) begin
      if (!sel_pend) begin
        np_busy <= 1'b0;
        np_fin  <= 1'b1;
      end
    end else if (np_req && launch_ok) begin
      np_busy <= 1'b1;
    end
  end

  // interface control: mode bit and soft reset request
  assign ifctl_wr   = bus_we && (bus_addr == OFS_IFCTL);
  assign srst_start = ifctl_wr && bus_wdata[IFCTL_SRST_BIT] && !resetting;

  always_ff @(posedge clk_b or negedge rst_b_n) begin
    if (!rst_b_n)        posted_q <= 1'b1;
    else if (srst_start) posted_q <= 1'b1;
    else if (ifctl_wr)   posted_q <= bus_wdata[IFCTL_POST_BIT];
  end

  pwt_srst #(.RST_CYC(RST_CYC)) u_srst (
    .clk_b(clk_b), .rst_b_n(rst_b_n), .start(srst_start), .busy(resetting),
    .clk_f(clk_f), .rst_f_n(rst_f_n), .f_clr(f_clr)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    pwt_lane #(.DATA_W(DATA_W)) u_lane (
      .clk_b(clk_b), .rst_b_n(rst_b_n),
      .launch(wr_launch[i]), .wdata(bus_wdata),
      .freeze(resetting), .shadow_clr(srst_start),
      .pend_raw(pend_raw[i]), .shadow(shadow[i]),
      .clk_f(clk_f), .rst_f_n(rst_f_n), .f_clr(f_clr),
      .f_val(fn_regs[i*DATA_W +: DATA_W]), .f_strobe(fn_wr_strobe[i])
    );
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      if (bus_addr == OFS_PENDING)
        bus_rdata = DATA_W'(pend_vec);
      else if (bus_addr == OFS_IFCTL)
        bus_rdata[IFCTL_POST_BIT] = posted_q;
      else if (bus_addr == OFS_SYSSTAT)
        bus_rdata[0] = !resetting;
      else if (sel.hit)
        bus_rdata = shadow[sel.idx];
    end
  end
endmodule

// File: rtl/pw_tracker_chk.sv
module pw_tracker_chk
  import pwt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                        clk_b,
  input logic                        rst_b_n,
  input logic                        clk_f,
  input logic                        rst_f_n,
  input logic                        bus_we,
  input logic                        bus_re,
  input logic                        bus_ready,
  input logic                        sel_hit,
  input logic                        posted_q,
  input logic [NUM_LANES-1:0]        sel_vec,
  input logic [NUM_LANES-1:0]        pend_vec,
  input logic [NUM_LANES-1:0]        wr_launch,
  input logic                        f_clr,
  input logic [NUM_LANES*DATA_W-1:0] fn_regs,
  input logic [NUM_LANES-1:0]        fn_wr_strobe
);
  a_r2_pend_after_launch: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (wr_launch != '0) |=> ((pend_vec & $past(wr_launch)) == $past(wr_launch)));

  a_r7_np_done_clean: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (bus_we && sel_hit && !posted_q && bus_ready) |-> ((pend_vec & sel_vec) == '0));

  a_r7_reads_no_stall: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (bus_re && !bus_we) |-> bus_ready);

  a_r3_regs_move_on_strobe: assert property (@(posedge clk_f) disable iff (!rst_f_n)
    !$stable(fn_regs) |-> ((fn_wr_strobe != '0) || $past(f_clr)));

  a_r8_clear_regs: assert property (@(posedge clk_f) disable iff (!rst_f_n)
    f_clr |=> (fn_regs == '0));
endmodule

bind pw_tracker pw_tracker_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_b(clk_b), .rst_b_n(rst_b_n), .clk_f(clk_f), .rst_f_n(rst_f_n),
  .bus_we(bus_we), .bus_re(bus_re), .bus_ready(bus_ready),
  .sel_hit(sel.hit), .posted_q(posted_q), .sel_vec(sel_vec),
  .pend_vec(pend_vec), .wr_launch(wr_launch), .f_clr(f_clr),
  .fn_regs(fn_regs), .fn_wr_strobe(fn_wr_strobe)
);

// File: tb/pw_tracker_bench.sv
module pw_tracker_bench;
  localparam int DW = 32;
  localparam int RC = 8;
  localparam int NL = 10;

  logic          clk_b = 0, clk_f = 0, rst_b_n = 0, rst_f_n = 0;
  logic [7:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic          bus_we = 0, bus_re = 0, bus_ready;
  logic [NL*DW-1:0] fn_regs;
  logic [NL-1:0]    fn_wr_strobe;

  always #5  clk_b = ~clk_b;
  always #13 clk_f = ~clk_f;

  pw_tracker #(.DATA_W(DW), .RST_CYC(RC)) u_pw_tracker (
    .clk_b(clk_b), .rst_b_n(rst_b_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .clk_f(clk_f), .rst_f_n(rst_f_n), .fn_regs(fn_regs), .fn_wr_strobe(fn_wr_strobe)
  );

  int total = 0, bad = 0;
  int exp_idx_q[$];
  logic [DW-1:0] exp_dat_q[$];

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lane_addr(input int i);
    if (i < 3)       return 8'(8'h24 + 4*i);
    else if (i == 3) return 8'h30;
    else if (i == 4) return 8'h38;
    else             return 8'(8'h48 + 4*(i-5));
  endfunction

  // monitor: every functional update must match the next expected item (R3)
  always @(negedge clk_f) begin
    if (rst_f_n) begin
      for (int i = 0; i < NL; i++) begin
        if (fn_wr_strobe[i]) begin
          if (exp_idx_q.size() == 0) begin
            chk(0, "R3 unexpected update", DW'(i), '1);
          end else begin
            int ei;
            logic [DW-1:0] ed;
            ei = exp_idx_q.pop_front();
            ed = exp_dat_q.pop_front();
            chk(ei == i, "R3 lane", DW'(i), DW'(ei));
            chk(fn_regs[i*DW +: DW] == ed, "R3 data", fn_regs[i*DW +: DW], ed);
          end
        end
      end
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [DW-1:0] d, output int stalls);
    stalls = 0;
    @(negedge clk_b);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    for (int k = 0; k < 2000; k++) begin
      #1;
      if (bus_ready) break;
      stalls++;
      @(negedge clk_b);
    end
    @(posedge clk_b);
    #1 bus_we = 0;
  endtask

  task automatic push_wr(input int lane, input logic [DW-1:0] d);
    int s;
    exp_idx_q.push_back(lane);
    exp_dat_q.push_back(d);
    bus_wr(lane_addr(lane), d, s);
    chk(s == 0, "R2 posted write stalled", DW'(s), 0);
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [DW-1:0] d);
    @(negedge clk_b);
    bus_addr = a; bus_re = 1;
    #1 d = bus_rdata;
    @(posedge clk_b);
    #1 bus_re = 0;
  endtask

  task automatic wait_clear(input logic [NL-1:0] m);
    logic [DW-1:0] v;
    for (int k = 0; k < 500; k++) begin
      bus_rd(8'h34, v);
      if ((v[NL-1:0] & m) == '0) return;
    end
    chk(0, "R2 pending never cleared", v, 0);
  endtask

  initial begin
    #1ms;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    int s, cyc;
    repeat (4) @(posedge clk_f);
    rst_b_n = 1; rst_f_n = 1;
    repeat (3) @(posedge clk_b);

    // reset state
    bus_rd(8'h14, v); chk(v == 1, "R8 reset-done after reset", v, 1);
    bus_rd(8'h40, v); chk(v == 32'h4, "R6 posted default", v, 32'h4);
    bus_rd(8'h34, v); chk(v == 0, "R1 pending idle", v, 0);

    // posted write, pending visible, stale read
    push_wr(0, 32'hA5A5_0001);
    bus_rd(8'h34, v); chk(v == 32'h1, "R2 pending set", v, 32'h1);
    bus_rd(8'h24, v); chk(v == 0, "R5 stale read", v, 0);
    wait_clear(10'h001);
    bus_rd(8'h24, v); chk(v == 32'hA5A5_0001, "R5 committed read", v, 32'hA5A5_0001);
    chk(fn_regs[31:0] == 32'hA5A5_0001, "R3 fn value", fn_regs[31:0], 32'hA5A5_0001);

    // second write while pending is lost
    push_wr(2, 32'h11);
    bus_wr(8'h2C, 32'h22, s);
    wait_clear(10'h004);
    bus_rd(8'h2C, v); chk(v == 32'h11, "R4 dropped write", v, 32'h11);
    chk(fn_regs[2*DW +: DW] == 32'h11, "R4 fn unchanged", fn_regs[2*DW +: DW], 32'h11);

    // several lanes in flight together
    push_wr(1, 32'hC1); push_wr(4, 32'hC4); push_wr(9, 32'hC9);
    bus_rd(8'h34, v); chk(v == 32'h212, "R1 multi pending", v, 32'h212);
    wait_clear('1);

    // each lane maps to its own pending bit
    for (int i = 0; i < NL; i++) begin
      push_wr(i, 32'h100 + i);
      bus_rd(8'h34, v);
      chk(v == (32'h1 << i), "R1 lane bit", v, 32'h1 << i);
      wait_clear('1);
      bus_rd(lane_addr(i), v);
      chk(v == 32'h100 + i, "R5 lane readback", v, 32'h100 + i);
    end

    // unsynchronized offset
    bus_wr(8'h10, 32'hDEAD, s);
    bus_rd(8'h34, v); chk(v == 0, "R10 no pending", v, 0);
    bus_rd(8'h10, v); chk(v == 0, "R10 reads zero", v, 0);
    repeat (20) @(posedge clk_b);

    // non-posted mode
    bus_wr(8'h40, 32'h0, s);
    bus_rd(8'h40, v); chk(v == 0, "R6 non-posted selected", v, 0);
    exp_idx_q.push_back(3); exp_dat_q.push_back(32'hBEEF);
    bus_wr(8'h30, 32'hBEEF, s);
    chk(s > 2, "R7 ready held low", DW'(s), 3);
    bus_rd(8'h34, v); chk(v == 0, "R7 no pending after", v, 0);
    bus_rd(8'h30, v); chk(v == 32'hBEEF, "R7 value", v, 32'hBEEF);

    // soft reset from non-posted mode, bit2 clear
    bus_wr(8'h40, 32'h2, s);
    cyc = 1;
    bus_wr(8'h38, 32'h77, s);
    cyc++;
    bus_rd(8'h14, v); cyc++;
    chk(v == 0, "R8 reset-done low", v, 0);
    for (int k = 0; k < 500 && v == 0; k++) begin
      bus_rd(8'h14, v); cyc++;
    end
    chk(cyc * 10 >= RC * 26, "R8 reset-done low time", DW'(cyc), DW'(RC * 26 / 10));
    chk(fn_regs == '0, "R8 fn regs cleared", fn_regs[31:0], 0);
    bus_rd(8'h24, v); chk(v == 0, "R8 read cleared", v, 0);
    bus_rd(8'h38, v); chk(v == 0, "R9 write in reset dropped", v, 0);
    bus_rd(8'h34, v); chk(v == 0, "R8 pending cleared", v, 0);
    bus_rd(8'h40, v); chk(v == 32'h4, "R8 posted restored", v, 32'h4);

    // normal operation resumes
    push_wr(0, 32'h99);
    wait_clear('1);
    bus_rd(8'h24, v); chk(v == 32'h99, "R3 after soft reset", v, 32'h99);
    repeat (20) @(posedge clk_b);
    chk(exp_idx_q.size() == 0, "R3 all updates seen", DW'(exp_idx_q.size()), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule